// File: doc/BRIEF.md
# Quad-Channel Double-Buffered DAC Register Bank

This block keeps the digital state behind a four-channel voltage-output converter with 8, 10 or 12 bits of resolution. It takes command words that a serial front end has already assembled. Each word carries an operation code, a channel selector and a 16-bit data field. Each channel has two register stages. The first is a staged (pending) code. The second is an active code that drives the converter. Codes reach the active stage in one of three ways: a commit command, a combined write-and-commit command, or the active-low load pin. While that pin is held low, the active stage of every channel that has the pin enabled follows its staged code.

The block also holds a two-bit reference selection, one power-down flag per channel and a per-channel mask for the load pin. A soft clear command zeroes all codes. A soft reset command zeroes all codes and returns the control fields to their defaults. An asynchronous clear pin zeroes all codes at once, without waiting for a clock. The active codes, the reference selection and the power-down flags are the block's outputs.

Top module: `dac_reg_bank`

## Requirements
- R1: After reset, every active code is zero, `ref_sel` is 0 (external reference), `pwr_down` is all zero, and every channel responds to the load pin.
- R2: Operation 4'h0 (stage) writes the staged code of each addressed channel and leaves its active code unchanged.
- R3: Operation 4'h1 (commit) copies the staged code into the active code of each addressed channel. The copy is visible on `dac_code` one cycle after the command.
- R4: Operation 4'h2 (stage and commit) writes both stages of each addressed channel. The new value is visible on `dac_code` one cycle after the command.
- R5: A selector value from 0 to 3 addresses that one channel, and 4'hF addresses all channels. Any other selector value makes a channel command do nothing.
- R6: The code is the top RES_BITS bits of `cmd_data` (left-justified). The lower data bits have no effect on the code. Channel c occupies `dac_code[c*RES_BITS +: RES_BITS]`.
- R7: The load pin `ldac_n` passes through a two-flop synchronizer. Two cycles after the pin goes low, and for as long as it stays low, each enabled channel's active code follows its staged code. A stage command issued during that time reaches `dac_code` one cycle after the command.
- R8: Operation 4'h5 sets the load-pin mask from `cmd_data[3:0]`. A 1 in bit c makes channel c ignore the pin.
- R9: Operation 4'h4 sets `pwr_down` from `cmd_data[3:0]`, where 1 means powered down. Stored codes are kept through power-down, and stage and commit commands still update them while a channel is powered down.
- R10: Operation 4'h6 sets `ref_sel` from `cmd_data[1:0]`: 0 selects external, 1 selects 2.048 V, 2 selects 2.500 V and 3 selects 4.096 V.
- R11: Operation 4'h7 (soft clear) zeroes every code and leaves the control fields as they are. Operation 4'h8 (soft reset) zeroes every code and also restores `ref_sel`, `pwr_down` and the mask to their reset values.
- R12: While `clr_n` is low, every active code reads zero without waiting for a clock edge, and channel commands are ignored. The control fields are kept.
- R13: Operation codes 4'h3 and 4'h9 through 4'hF have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr_n | input | 1 | Asynchronous active-low clear of all channel codes |
| ldac_n | input | 1 | Active-low load pin, level sensitive |
| cmd_valid | input | 1 | Command word is present this cycle |
| cmd_op | input | 4 | Operation code |
| cmd_sel | input | 4 | Channel selector |
| cmd_data | input | 16 | Left-justified data field |
| dac_code | output | 48 | Active codes, channel c at bits c*12 +: 12 |
| ref_sel | output | 2 | Reference selection |
| pwr_down | output | 4 | Per-channel power-down flags |

## Verification
A staged code is never visible at the ports until something promotes it, so a corrupted staged value stays hidden. It shows up on `dac_code` one cycle after the next commit, or three cycles after the load pin falls. For this reason the bench always promotes every staged value before it relies on it. A wrong mask or a wrong load-pin synchronizer shows as an active code that changes one cycle early or late, or not at all, while the pin is low. Errors in the reference and power-down fields appear on the ports one cycle after the command that writes them. A reference model of the block is compared with every output on every cycle, so each fault is caught at its first visible cycle.

// File: rtl/dac_regs_pkg.sv
package dac_regs_pkg;

  typedef enum logic [3:0] {
    OP_STAGE        = 4'h0,
    OP_COMMIT       = 4'h1,
    OP_STAGE_COMMIT = 4'h2,
    OP_POWER        = 4'h4,
    OP_LDAC_MASK    = 4'h5,
    OP_REF          = 4'h6,
    OP_WIPE         = 4'h7,
    OP_SOFT_RESET   = 4'h8
  } dac_op_e;

  localparam logic [1:0] REF_EXTERNAL = 2'd0;

endpackage

// File: rtl/dac_rst_sync.sv
module dac_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;

endmodule

// File: rtl/dac_ldac_sync.sv
module dac_ldac_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic load_active
);

  logic s1_q;
  logic s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= pin_n;
      s2_q <= s1_q;
    end
  end

  assign load_active = ~s2_q;

  // R7
  ldac_two_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_active |-> ($past(pin_n, 2) == 1'b0));

endmodule

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_regs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SEL_W  = 4,
  parameter int OP_W   = 4
) (
  input  logic              cmd_valid,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [SEL_W-1:0]  cmd_sel,
  output logic [NUM_CH-1:0] ch_stage,
  output logic [NUM_CH-1:0] ch_commit,
  output logic [NUM_CH-1:0] ch_direct,
  output logic              wr_power,
  output logic              wr_mask,
  output logic              wr_ref,
  output logic              wipe_codes,
  output logic              soft_reset
);

  logic              sel_all;
  logic [NUM_CH-1:0] sel_hit;
  logic              is_stage;
  logic              is_commit;
  logic              is_direct;

  assign sel_all = &cmd_sel;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
      assign sel_hit[c] = sel_all || (cmd_sel == SEL_W'(c));
    end
  endgenerate

  always_comb begin
    is_stage   = cmd_valid && (cmd_op == OP_STAGE);
    is_commit  = cmd_valid && (cmd_op == OP_COMMIT);
    is_direct  = cmd_valid && (cmd_op == OP_STAGE_COMMIT);
    wr_power   = cmd_valid && (cmd_op == OP_POWER);
    wr_mask    = cmd_valid && (cmd_op == OP_LDAC_MASK);
    wr_ref     = cmd_valid && (cmd_op == OP_REF);
    soft_reset = cmd_valid && (cmd_op == OP_SOFT_RESET);
    wipe_codes = soft_reset || (cmd_valid && (cmd_op == OP_WIPE));
    ch_stage   = is_stage  ? sel_hit : '0;
    ch_commit  = is_commit ? sel_hit : '0;
    ch_direct  = is_direct ? sel_hit : '0;
  end

endmodule

// File: rtl/dac_channel.sv
module dac_channel #(
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_stage,
  input  logic                wr_commit,
  input  logic                wr_direct,
  input  logic                wipe,
  input  logic                load_active,
  input  logic                load_enable,
  input  logic [RES_BITS-1:0] new_code,
  output logic [RES_BITS-1:0] active_code
);

  logic [RES_BITS-1:0] stage_q, stage_d;
  logic [RES_BITS-1:0] active_q, active_d;
  logic                stage_en;
  logic                active_en;
  logic                transparent;

  assign transparent = load_active && load_enable;

  always_comb begin
    stage_en = wipe || wr_stage || wr_direct;
    stage_d  = stage_q;
    if (wipe)
      stage_d = '0;
    else if (wr_stage || wr_direct)
      stage_d = new_code;
  end

  always_comb begin
    active_en = wipe || transparent || wr_direct || wr_commit;
    active_d  = active_q;
    if (wipe)
      active_d = '0;
    else if (transparent)
      active_d = stage_d;
    else if (wr_direct)
      active_d = new_code;
    else if (wr_commit)
      active_d = stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      active_q <= '0;
    end else begin
      if (stage_en)
        stage_q <= stage_d;
      if (active_en)
        active_q <= active_d;
    end
  end

  assign active_code = active_q;

  // R2
  stage_only_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stage && !wr_direct && !wr_commit && !wipe && !transparent)
      |=> (active_q == $past(active_q)));

  // R3
  commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && !wipe && !transparent) |=> (active_q == $past(stage_q)));

  // R4
  direct_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_direct && !wipe) |=> ((active_q == $past(new_code)) && (stage_q == $past(new_code))));

  // R7
  transparent_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (transparent && !wipe) |=> (active_q == stage_q));

  // R11
  wipe_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> ((active_q == '0) && (stage_q == '0)));

endmodule

// File: rtl/dac_ctrl_regs.sv
module dac_ctrl_regs
  import dac_regs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CTRL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_power,
  input  logic              wr_mask,
  input  logic              wr_ref,
  input  logic              soft_reset,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [1:0]        ref_sel,
  output logic [NUM_CH-1:0] pwr_down,
  output logic [NUM_CH-1:0] ldac_ignore
);

  logic [1:0]        ref_q, ref_d;
  logic [NUM_CH-1:0] pwr_q, pwr_d;
  logic [NUM_CH-1:0] mask_q, mask_d;
  logic              ref_en, pwr_en, mask_en;

  always_comb begin
    ref_en  = wr_ref || soft_reset;
    pwr_en  = wr_power || soft_reset;
    mask_en = wr_mask || soft_reset;
    ref_d   = soft_reset ? REF_EXTERNAL : wr_data[1:0];
    pwr_d   = soft_reset ? '0 : wr_data[NUM_CH-1:0];
    mask_d  = soft_reset ? '0 : wr_data[NUM_CH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= REF_EXTERNAL;
      pwr_q  <= '0;
      mask_q <= '0;
    end else begin
      if (ref_en)
        ref_q <= ref_d;
      if (pwr_en)
        pwr_q <= pwr_d;
      if (mask_en)
        mask_q <= mask_d;
    end
  end

  assign ref_sel     = ref_q;
  assign pwr_down    = pwr_q;
  assign ldac_ignore = mask_q;

  // R10
  ref_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ref && !soft_reset) |=> (ref_sel == $past(wr_data[1:0])));

  // R9
  power_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_power && !soft_reset) |=> (pwr_down == $past(wr_data[NUM_CH-1:0])));

  // R11
  soft_reset_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset |=> ((ref_sel == REF_EXTERNAL) && (pwr_down == '0) && (ldac_ignore == '0)));

endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank
  import dac_regs_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int RES_BITS = 12,
  parameter int DATA_W   = 16,
  parameter int SEL_W    = 4,
  parameter int OP_W     = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr_n,
  input  logic                         ldac_n,
  input  logic                         cmd_valid,
  input  logic [OP_W-1:0]              cmd_op,
  input  logic [SEL_W-1:0]             cmd_sel,
  input  logic [DATA_W-1:0]            cmd_data,
  output logic [NUM_CH*RES_BITS-1:0]   dac_code,
  output logic [1:0]                   ref_sel,
  output logic [NUM_CH-1:0]            pwr_down
);

  localparam int CTRL_W = (NUM_CH > 2) ? NUM_CH : 2;

  logic                core_rst_n;
  logic                data_arst_n;
  logic                data_rst_n;
  logic                load_active;
  logic [NUM_CH-1:0]   ch_stage, ch_commit, ch_direct;
  logic [NUM_CH-1:0]   ldac_ignore;
  logic                wr_power, wr_mask, wr_ref, wipe_codes, soft_reset;
  logic [RES_BITS-1:0] new_code;

  assign data_arst_n = rst_n & clr_n;
  assign new_code    = cmd_data[DATA_W-1 -: RES_BITS];

  dac_rst_sync u_core_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (core_rst_n)
  );

  dac_rst_sync u_data_rst (
    .clk    (clk),
    .arst_n (data_arst_n),
    .srst_n (data_rst_n)
  );

  dac_ldac_sync u_ldac (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .pin_n       (ldac_n),
    .load_active (load_active)
  );

  dac_cmd_decode #(
    .NUM_CH (NUM_CH),
    .SEL_W  (SEL_W),
    .OP_W   (OP_W)
  ) u_decode (
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_sel    (cmd_sel),
    .ch_stage   (ch_stage),
    .ch_commit  (ch_commit),
    .ch_direct  (ch_direct),
    .wr_power   (wr_power),
    .wr_mask    (wr_mask),
    .wr_ref     (wr_ref),
    .wipe_codes (wipe_codes),
    .soft_reset (soft_reset)
  );

  dac_ctrl_regs #(
    .NUM_CH (NUM_CH),
    .CTRL_W (CTRL_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .wr_power    (wr_power),
    .wr_mask     (wr_mask),
    .wr_ref      (wr_ref),
    .soft_reset  (soft_reset),
    .wr_data     (cmd_data[CTRL_W-1:0]),
    .ref_sel     (ref_sel),
    .pwr_down    (pwr_down),
    .ldac_ignore (ldac_ignore)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [RES_BITS-1:0] code_c;

      dac_channel #(
        .RES_BITS (RES_BITS)
      ) u_ch (
        .clk         (clk),
        .rst_n       (data_rst_n),
        .wr_stage    (ch_stage[c]),
        .wr_commit   (ch_commit[c]),
        .wr_direct   (ch_direct[c]),
        .wipe        (wipe_codes),
        .load_active (load_active),
        .load_enable (~ldac_ignore[c]),
        .new_code    (new_code),
        .active_code (code_c)
      );

      assign dac_code[c*RES_BITS +: RES_BITS] = code_c;
    end
  endgenerate

  // R5
  sel_fanout_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (($countones(ch_direct) <= 1) || (&ch_direct)) &&
    (($countones(ch_stage) <= 1) || (&ch_stage)));

  // R13
  undefined_op_quiet_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (cmd_valid && (cmd_op == 4'h3 || cmd_op >= 4'h9))
      |-> ((ch_stage == '0) && (ch_commit == '0) && (ch_direct == '0) &&
           !wr_power && !wr_mask && !wr_ref && !wipe_codes));

  // R12
  clear_zero_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    !data_rst_n |-> (dac_code == '0));

endmodule

// File: tb/tb_dac_reg_bank.sv
`timescale 1ns/1ps
module tb_dac_reg_bank;

  localparam int N   = 4;
  localparam int RES = 12;

  logic          clk = 1'b0;
  logic          rst_n, clr_n, ldac_n, cmd_valid;
  logic [3:0]    cmd_op, cmd_sel;
  logic [15:0]   cmd_data;
  logic [N*RES-1:0] dac_code;
  logic [1:0]    ref_sel;
  logic [N-1:0]  pwr_down;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int m_code [N];
  int m_dac  [N];
  int m_ref, m_pwr, m_mask;
  bit m_s1, m_s2, m_clr;

  always #2.5 clk = ~clk;

  dac_reg_bank dut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ldac_n(ldac_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_sel(cmd_sel), .cmd_data(cmd_data),
    .dac_code(dac_code), .ref_sel(ref_sel), .pwr_down(pwr_down)
  );

  function automatic bit hits(input int sel, input int ch);
    return (sel == 15) || (sel == ch);
  endfunction

  // Behavioural reference model, updated on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < N; c++) begin m_code[c] = 0; m_dac[c] = 0; end
      m_ref = 0; m_pwr = 0; m_mask = 0; m_s1 = 1; m_s2 = 1;
    end else begin
      bit pin_low;
      int op, sel, nc;
      pin_low = !m_s2;
      op  = cmd_valid ? int'(cmd_op) : -1;
      sel = int'(cmd_sel);
      nc  = int'(cmd_data) >> (16 - RES);
      if (!m_clr) begin
        for (int c = 0; c < N; c++) begin
          int old_code;
          old_code = m_code[c];
          if (op == 7 || op == 8) begin
            m_code[c] = 0; m_dac[c] = 0;
          end else begin
            if ((op == 0 || op == 2) && hits(sel, c)) m_code[c] = nc;
            if (pin_low && !m_mask[c]) m_dac[c] = m_code[c];
            else if (op == 2 && hits(sel, c)) m_dac[c] = nc;
            else if (op == 1 && hits(sel, c)) m_dac[c] = old_code;
          end
        end
      end
      if (op == 4) m_pwr  = int'(cmd_data) & ((1 << N) - 1);
      if (op == 5) m_mask = int'(cmd_data) & ((1 << N) - 1);
      if (op == 6) m_ref  = int'(cmd_data) & 3;
      if (op == 8) begin m_ref = 0; m_pwr = 0; m_mask = 0; end
      m_s2 = m_s1;
      m_s1 = ldac_n;
    end
  end

  // Cycle-by-cycle comparison of every output against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      for (int c = 0; c < N; c++) begin
        total++;
        if (int'(dac_code[c*RES +: RES]) != m_dac[c]) begin
          bad++;
          $display("FAIL R2/R3/R4/R7 model compare ch%0d: actual=%h expected=%h",
                   c, dac_code[c*RES +: RES], m_dac[c]);
        end
      end
      total++;
      if (int'(ref_sel) != m_ref || int'(pwr_down) != m_pwr) begin
        bad++;
        $display("FAIL R9/R10 model compare: actual ref=%0d pwr=%h expected ref=%0d pwr=%h",
                 ref_sel, pwr_down, m_ref, m_pwr);
      end
    end
  end

  task automatic check(input string req, input int actual, input int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, actual, expected);
    end
  endtask

  function automatic int ch(input int c);
    return int'(dac_code[c*RES +: RES]);
  endfunction

  task automatic send(input logic [3:0] op, input logic [3:0] sel, input logic [15:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_sel = sel; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 4'h0; cmd_sel = 4'h0; cmd_data = 16'h0;
    #2;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int snap [N];
    rst_n = 0; clr_n = 1; ldac_n = 1; cmd_valid = 0;
    cmd_op = 0; cmd_sel = 0; cmd_data = 0; m_clr = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    idle(4);

    // R1 reset state
    check("R1 codes", int'(dac_code == '0), 1);
    check("R1 ref_sel", int'(ref_sel), 0);
    check("R1 pwr_down", int'(pwr_down), 0);

    // R2 stage only
    send(4'h0, 4'h0, 16'hABC0);
    check("R2 active unchanged", ch(0), 0);
    // R3 commit
    send(4'h1, 4'h0, 16'h0000);
    check("R3 commit ch0", ch(0), 12'hABC);
    // R4 + R6
    send(4'h2, 4'h2, 16'h1234);
    check("R4 direct ch2", ch(2), 12'h123);
    check("R6 low bits dropped ch2", ch(2), 12'h123);
    // R5 broadcast and ignored selector
    send(4'h2, 4'hF, 16'hFFF0);
    for (int c = 0; c < N; c++) check("R5 broadcast", ch(c), 12'hFFF);
    send(4'h2, 4'h5, 16'h0000);
    for (int c = 0; c < N; c++) check("R5 bad selector ignored", ch(c), 12'hFFF);
    send(4'h2, 4'h3, 16'h000F);
    check("R6 only low bits set", ch(3), 0);

    // R13 undefined operations
    send(4'h3, 4'hF, 16'h0000);
    send(4'h9, 4'hF, 16'h0000);
    send(4'hF, 4'h0, 16'h0003);
    check("R13 no code change", ch(0), 12'hFFF);
    check("R13 no ref change", int'(ref_sel), 0);

    // R9 power-down keeps codes and accepts updates
    send(4'h4, 4'h0, 16'h0005);
    check("R9 pwr_down", int'(pwr_down), 5);
    send(4'h2, 4'h0, 16'h5550);
    check("R9 update while down", ch(0), 12'h555);
    send(4'h4, 4'h0, 16'h0000);
    check("R9 code kept on power-up", ch(0), 12'h555);
    check("R9 ch1 kept", ch(1), 12'hFFF);

    // R10 reference selection
    send(4'h6, 4'h0, 16'h0002);
    check("R10 ref 2.5V", int'(ref_sel), 2);
    send(4'h6, 4'h0, 16'h0003);
    check("R10 ref 4.096V", int'(ref_sel), 3);

    // R7 load pin, all channels enabled (R1)
    send(4'h0, 4'h1, 16'h7770);
    check("R7 staged not active", ch(1), 12'hFFF);
    @(negedge clk); ldac_n = 1'b0;
    idle(2);
    check("R7 not yet after two edges", ch(1), 12'hFFF);
    idle(1);
    check("R7 transparent after sync", ch(1), 12'h777);
    check("R1 ch0 responds to pin", ch(0), 12'h555);
    send(4'h0, 4'h1, 16'h8880);
    check("R7 passes while low", ch(1), 12'h888);
    @(negedge clk); ldac_n = 1'b1;
    idle(3);

    // R8 mask
    send(4'h5, 4'h0, 16'h0002);
    send(4'h0, 4'h1, 16'h9990);
    send(4'h0, 4'h2, 16'h4440);
    @(negedge clk); ldac_n = 1'b0;
    idle(3);
    check("R8 enabled ch2 follows", ch(2), 12'h444);
    check("R8 masked ch1 holds", ch(1), 12'h888);
    @(negedge clk); ldac_n = 1'b1;
    idle(3);
    send(4'h1, 4'h1, 16'h0000);
    check("R8 masked staged value intact", ch(1), 12'h999);

    // R11 soft clear keeps control
    send(4'h4, 4'h0, 16'h0003);
    send(4'h7, 4'h0, 16'h0000);
    for (int c = 0; c < N; c++) check("R11 clear zero", ch(c), 0);
    check("R11 clear keeps ref", int'(ref_sel), 3);
    check("R11 clear keeps pwr", int'(pwr_down), 3);
    send(4'h2, 4'hF, 16'h2220);
    send(4'h8, 4'h0, 16'h0000);
    check("R11 reset zero code", ch(3), 0);
    check("R11 reset ref", int'(ref_sel), 0);
    check("R11 reset pwr", int'(pwr_down), 0);

    // R12 asynchronous clear
    send(4'h6, 4'h0, 16'h0001);
    send(4'h2, 4'hF, 16'h6660);
    @(negedge clk);
    clr_n = 1'b0; m_clr = 1'b1;
    for (int c = 0; c < N; c++) begin m_code[c] = 0; m_dac[c] = 0; end
    #0.5;
    check("R12 immediate zero", int'(dac_code == '0), 1);
    cmd_valid = 1'b1; cmd_op = 4'h2; cmd_sel = 4'hF; cmd_data = 16'h7770;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 4'h0; cmd_sel = 4'h0; cmd_data = 16'h0;
    clr_n = 1'b1;
    idle(4);
    m_clr = 1'b0;
    check("R12 command ignored", int'(dac_code == '0), 1);
    check("R12 ref kept", int'(ref_sel), 1);
    send(4'h2, 4'h0, 16'h3330);
    check("R12 writes resume", ch(0), 12'h333);
    for (int c = 0; c < N; c++) snap[c] = ch(c);
    idle(2);
    check("R12 stable", ch(0), snap[0]);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule